// File: doc/BRIEF.md
# Commit Thread Selector

In a multithreaded out-of-order core, the retirement stage may serve only one hardware thread in each commit slot. This block names that thread. For every thread it receives a commit-status code, a flag that says whether the thread's reorder buffer is empty, a flag that says whether the oldest instruction is ready to retire, and that instruction's sequence number. It returns a valid flag and a thread index. When the valid flag is low, the retirement loop stops for the cycle.

A policy code is captured during reset and selects one of three arbitration schemes:
- **Aggressive** and **oldest-ready** pick the ready thread whose oldest instruction has the smallest sequence number.
- **Round-robin** scans a rotating priority order. It moves the winner to the back of that order when the retirement logic confirms the pick with a grant strobe.

The selection is combinational, so the retirement logic can consult it several times within one cycle. Only the rotation is registered. A build with a single thread skips arbitration: it returns thread 0 whenever that thread's status allows it.

Top module: `commit_thread_sel`

## Requirements
- R1: Status codes are 3 bits: 0 idle, 1 running, 2 reorder-buffer squashing, 3 trap pending, 4 fetch-trap pending. Only codes 0, 1 and 4 make a thread eligible. A thread in code 2 or 3 is never selected.
- R2: A thread is a candidate in the multi-thread build only when it is eligible, its reorder buffer is not empty, and its head-ready flag is set.
- R3: With policy code 2 (oldest-ready), the candidate with the smallest head sequence number is selected.
- R4: When two candidates have the same sequence number, the lower thread index wins.
- R5: Policy code 0 (aggressive) and code 3 select exactly as oldest-ready does. The result follows input changes within the same cycle, with no clock edge needed.
- R6: With policy code 1 (round-robin), the first candidate found in the priority order is selected.
- R7: After reset, the priority order is ascending thread index, with thread 0 first.
- R8: In round-robin, a grant_i sampled high while sel_valid_o is high moves the selected thread to the tail of the order. The relative order of the other threads is kept. Without a grant, the order is unchanged.
- R9: When no thread qualifies, sel_valid_o is 0 and sel_tid_o is 0.
- R10: With NUM_THREADS = 1, sel_valid_o equals thread 0's eligibility. The reorder-buffer empty and head-ready flags are ignored, and sel_tid_o is 0.
- R11: The policy is captured only while rst is high. Changes to policy_i after reset have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures policy_i |
| policy_i | input | 2 | Arbitration policy code (0 aggressive, 1 round-robin, 2 oldest-ready, 3 as oldest-ready) |
| status_i | input | NUM_THREADS*3 | Per-thread commit-status code; thread t uses bits [3t+2:3t] |
| rob_empty_i | input | NUM_THREADS | Per-thread reorder buffer empty flag |
| head_ready_i | input | NUM_THREADS | Per-thread oldest-instruction ready flag |
| head_seq_i | input | NUM_THREADS*SEQ_W | Per-thread head sequence number; thread t uses bits [SEQ_W*t +: SEQ_W] |
| grant_i | input | 1 | Retirement logic takes the current selection (rotates the round-robin order) |
| sel_valid_o | output | 1 | A thread is selected |
| sel_tid_o | output | TID_W | Selected thread index (0 when none is selected) |

## Verification
The bench builds two copies of the block.

The first uses four threads and 16-bit sequence numbers. Four threads are enough to walk the round-robin order through a full rotation, and to move a winner from the middle of the order to its tail, which exposes any loss of the other threads' order. They also allow sequence-number ties between threads that are not neighbours.

The second copy uses one thread, which reaches the single-thread shortcut. In that build, an empty buffer and a head that is not ready must still yield a selection.

// File: rtl/cts_pkg.sv
package cts_pkg;
  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_RUNNING    = 3'd1,
    ST_ROB_SQUASH = 3'd2,
    ST_TRAP_PEND  = 3'd3,
    ST_FETCH_TRAP = 3'd4
  } commit_status_e;

  localparam int unsigned STATUS_W = 3;

  localparam logic [1:0] POL_AGGR   = 2'd0;
  localparam logic [1:0] POL_RR     = 2'd1;
  localparam logic [1:0] POL_OLDEST = 2'd2;

  function automatic logic status_eligible(input logic [STATUS_W-1:0] s);
    return (s == ST_IDLE) || (s == ST_RUNNING) || (s == ST_FETCH_TRAP);
  endfunction
endpackage

// File: rtl/cts_eligible.sv
module cts_eligible import cts_pkg::*; #(
  parameter int NUM_THREADS = 4
) (
  input  logic [NUM_THREADS*STATUS_W-1:0] status_i,
  input  logic [NUM_THREADS-1:0]          rob_empty_i,
  input  logic [NUM_THREADS-1:0]          head_ready_i,
  output logic [NUM_THREADS-1:0]          elig_o,
  output logic [NUM_THREADS-1:0]          cand_o
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    assign elig_o[t] = status_eligible(status_i[t*STATUS_W +: STATUS_W]);
    assign cand_o[t] = elig_o[t] & ~rob_empty_i[t] & head_ready_i[t];
  end
endmodule

// File: rtl/cts_oldest.sv
module cts_oldest #(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W       = 16,
  parameter int TID_W       = 2
) (
  input  logic [NUM_THREADS-1:0]       cand_i,
  input  logic [NUM_THREADS*SEQ_W-1:0] seq_i,
  output logic                         found_o,
  output logic [TID_W-1:0]             tid_o
);
  logic [SEQ_W-1:0] best_seq;

  always_comb begin
    found_o  = 1'b0;
    tid_o    = '0;
    best_seq = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      // strict compare keeps the lower index on equal sequence numbers
      if (cand_i[t] && (!found_o || seq_i[t*SEQ_W +: SEQ_W] < best_seq)) begin
        found_o  = 1'b1;
        tid_o    = TID_W'(t);
        best_seq = seq_i[t*SEQ_W +: SEQ_W];
      end
    end
  end
endmodule

// File: rtl/cts_rr_list.sv
module cts_rr_list #(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_THREADS-1:0] cand_i,
  input  logic                   rotate_i,
  output logic                   found_o,
  output logic [TID_W-1:0]       tid_o
);
  logic [TID_W-1:0] order_q [NUM_THREADS];
  logic [TID_W-1:0] order_d [NUM_THREADS];
  logic [TID_W-1:0] win_pos;

  always_comb begin
    found_o = 1'b0;
    win_pos = '0;
    for (int p = 0; p < NUM_THREADS; p++) begin
      if (!found_o && cand_i[order_q[p]]) begin
        found_o = 1'b1;
        win_pos = TID_W'(p);
      end
    end
    tid_o = found_o ? order_q[win_pos] : '0;
  end

  // Entries behind the winner move up one slot; the winner goes last.
  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_slot
    if (g < NUM_THREADS - 1) begin : g_mid
      assign order_d[g] = (TID_W'(g) >= win_pos) ? order_q[g+1] : order_q[g];
    end else begin : g_tail
      assign order_d[g] = order_q[win_pos];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NUM_THREADS; p++) order_q[p] <= TID_W'(p);
    end else if (rotate_i && found_o) begin
      for (int p = 0; p < NUM_THREADS; p++) order_q[p] <= order_d[p];
    end
  end
endmodule

// File: rtl/commit_thread_sel.sv
module commit_thread_sel import cts_pkg::*; #(
  parameter  int NUM_THREADS = 4,
  parameter  int SEQ_W       = 16,
  localparam int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [1:0]                      policy_i,
  input  logic [NUM_THREADS*STATUS_W-1:0] status_i,
  input  logic [NUM_THREADS-1:0]          rob_empty_i,
  input  logic [NUM_THREADS-1:0]          head_ready_i,
  input  logic [NUM_THREADS*SEQ_W-1:0]    head_seq_i,
  input  logic                            grant_i,
  output logic                            sel_valid_o,
  output logic [TID_W-1:0]                sel_tid_o
);
  logic [1:0]             policy_q;
  logic [NUM_THREADS-1:0] elig;
  logic [NUM_THREADS-1:0] cand;

  always_ff @(posedge clk) begin
    if (rst) policy_q <= policy_i;
  end

  cts_eligible #(.NUM_THREADS(NUM_THREADS)) u_elig (
    .status_i     (status_i),
    .rob_empty_i  (rob_empty_i),
    .head_ready_i (head_ready_i),
    .elig_o       (elig),
    .cand_o       (cand)
  );

  if (NUM_THREADS == 1) begin : g_single
    assign sel_valid_o = elig[0];
    assign sel_tid_o   = '0;
  end else begin : g_multi
    logic             old_found, rr_found, use_rr;
    logic [TID_W-1:0] old_tid, rr_tid;

    assign use_rr = (policy_q == POL_RR);

    cts_oldest #(.NUM_THREADS(NUM_THREADS), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_old (
      .cand_i  (cand),
      .seq_i   (head_seq_i),
      .found_o (old_found),
      .tid_o   (old_tid)
    );

    cts_rr_list #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_rr (
      .clk      (clk),
      .rst      (rst),
      .cand_i   (cand),
      .rotate_i (grant_i & use_rr),
      .found_o  (rr_found),
      .tid_o    (rr_tid)
    );

    assign sel_valid_o = use_rr ? rr_found : old_found;
    assign sel_tid_o   = use_rr ? rr_tid   : old_tid;
  end
endmodule

// File: rtl/cts_checker.sv
module cts_checker #(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W       = 16,
  parameter int TID_W       = 2
) (
  input logic                         clk,
  input logic                         rst,
  input logic [1:0]                   pol,
  input logic [NUM_THREADS*3-1:0]     status,
  input logic [NUM_THREADS-1:0]       rob_empty,
  input logic [NUM_THREADS-1:0]       head_ready,
  input logic [NUM_THREADS*SEQ_W-1:0] head_seq,
  input logic                         grant,
  input logic                         sel_valid,
  input logic [TID_W-1:0]             sel_tid
);
  logic [2:0]       sel_st;
  logic             sel_rdy, sel_emp, older_exists, any_cand;
  logic [SEQ_W-1:0] sel_seq;

  always_comb begin
    sel_st = '0; sel_rdy = 1'b0; sel_emp = 1'b1; sel_seq = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (TID_W'(t) == sel_tid) begin
        sel_st  = status[t*3 +: 3];
        sel_rdy = head_ready[t];
        sel_emp = rob_empty[t];
        sel_seq = head_seq[t*SEQ_W +: SEQ_W];
      end
    end
    older_exists = 1'b0;
    any_cand     = 1'b0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      logic [2:0] s;
      logic       c;
      s = status[t*3 +: 3];
      c = (s == 3'd0 || s == 3'd1 || s == 3'd4) && !rob_empty[t] && head_ready[t];
      any_cand = any_cand | c;
      if (c && (head_seq[t*SEQ_W +: SEQ_W] < sel_seq ||
               (head_seq[t*SEQ_W +: SEQ_W] == sel_seq && TID_W'(t) < sel_tid)))
        older_exists = 1'b1;
    end
  end

  assert_sel_eligible_R1: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> (sel_st != 3'd2 && sel_st != 3'd3));

  assert_none_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !sel_valid |-> sel_tid == '0);

  assert_tid_range_R9: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> int'(sel_tid) < NUM_THREADS);

  assert_policy_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(pol));

  if (NUM_THREADS > 1) begin : g_multi_chk
    assert_ready_head_R2: assert property (@(posedge clk) disable iff (rst)
      sel_valid |-> (sel_rdy && !sel_emp));

    assert_oldest_min_R3: assert property (@(posedge clk) disable iff (rst)
      (pol != 2'd1 && sel_valid) |-> !older_exists);

    assert_found_R9: assert property (@(posedge clk) disable iff (rst)
      any_cand |-> sel_valid);
  end else begin : g_single_chk
    assert_single_R10: assert property (@(posedge clk) disable iff (rst)
      sel_valid == (status[2:0] == 3'd0 || status[2:0] == 3'd1 || status[2:0] == 3'd4));
  end

  logic unused_grant;
  assign unused_grant = grant;
endmodule

bind commit_thread_sel cts_checker #(
  .NUM_THREADS(NUM_THREADS), .SEQ_W(SEQ_W), .TID_W(TID_W)
) u_cts_chk (
  .clk        (clk),
  .rst        (rst),
  .pol        (policy_q),
  .status     (status_i),
  .rob_empty  (rob_empty_i),
  .head_ready (head_ready_i),
  .head_seq   (head_seq_i),
  .grant      (grant_i),
  .sel_valid  (sel_valid_o),
  .sel_tid    (sel_tid_o)
);

// File: tb/commit_thread_sel_tb.sv
module commit_thread_sel_tb;
  localparam int N  = 4;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    pol = 2'd1;
  logic [N*3-1:0]  st  = '0;
  logic [N-1:0]    emp = '0;
  logic [N-1:0]    rdy = '0;
  logic [N*SW-1:0] seq = '0;
  logic          grant = 1'b0;
  logic          sel_valid;
  logic [1:0]    sel_tid;

  logic [2:0]    st1 = 3'd2;
  logic          emp1 = 1'b1, rdy1 = 1'b0, grant1 = 1'b0;
  logic [SW-1:0] seq1 = '0;
  logic          one_valid;
  logic [0:0]    one_tid;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  commit_thread_sel #(.NUM_THREADS(N), .SEQ_W(SW)) u_dut (
    .clk(clk), .rst(rst), .policy_i(pol), .status_i(st), .rob_empty_i(emp),
    .head_ready_i(rdy), .head_seq_i(seq), .grant_i(grant),
    .sel_valid_o(sel_valid), .sel_tid_o(sel_tid));

  commit_thread_sel #(.NUM_THREADS(1), .SEQ_W(SW)) u_one (
    .clk(clk), .rst(rst), .policy_i(pol), .status_i(st1), .rob_empty_i(emp1),
    .head_ready_i(rdy1), .head_seq_i(seq1), .grant_i(grant1),
    .sel_valid_o(one_valid), .sel_tid_o(one_tid));

  task automatic expect_sel(string req, bit ev, int et);
    n_chk++;
    if (sel_valid !== ev || int'(sel_tid) != et) begin
      n_fail++;
      $display("FAIL %s: actual valid=%0b tid=%0d expected valid=%0b tid=%0d",
               req, sel_valid, sel_tid, ev, et);
    end
  endtask

  task automatic expect_one(string req, bit ev);
    n_chk++;
    if (one_valid !== ev || one_tid !== 1'b0) begin
      n_fail++;
      $display("FAIL %s: actual valid=%0b tid=%0d expected valid=%0b tid=0",
               req, one_valid, one_tid, ev);
    end
  endtask

  task automatic set_t(int i, logic [2:0] s, bit e, bit r, int q);
    st[i*3 +: 3]    = s;
    emp[i]          = e;
    rdy[i]          = r;
    seq[i*SW +: SW] = SW'(q);
  endtask

  task automatic all_run(int q0, int q1, int q2, int q3);
    set_t(0, 3'd1, 0, 1, q0); set_t(1, 3'd1, 0, 1, q1);
    set_t(2, 3'd1, 0, 1, q2); set_t(3, 3'd1, 0, 1, q3);
  endtask

  task automatic do_reset(logic [1:0] p);
    @(negedge clk); rst = 1'b1; pol = p;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic settle;
    @(negedge clk); #1;
  endtask

  task automatic do_grant;
    @(negedge clk); grant = 1'b1;
    @(negedge clk); grant = 1'b0;
    #1;
  endtask

  task automatic t_reset_state;
    for (int i = 0; i < N; i++) set_t(i, 3'd2, 0, 1, i);
    do_reset(2'd1);
    #1;
    expect_sel("R9 reset, all squashing", 0, 0);
    expect_one("R1 single squashing at reset", 0);
  endtask

  task automatic t_rr_rotate;
    all_run(0, 0, 0, 0);
    settle(); expect_sel("R7 initial order head", 1, 0);
    rdy = 4'b1100;
    settle(); expect_sel("R7 ascending scan", 1, 2);
    rdy = 4'b1111;
    settle();
    do_grant(); expect_sel("R8 rotate after grant 0", 1, 1);
    do_grant(); expect_sel("R8 rotate after grant 1", 1, 2);
    do_grant(); expect_sel("R8 rotate after grant 2", 1, 3);
    do_grant(); expect_sel("R8 full rotation back to 0", 1, 0);
    rdy = 4'b0100;
    settle(); expect_sel("R6 only thread 2 ready", 1, 2);
    do_grant();
    rdy = 4'b1111;
    settle(); expect_sel("R8 order kept ahead of moved entry", 1, 0);
    rdy = 4'b1110;
    settle(); expect_sel("R8 second in order", 1, 1);
    rdy = 4'b1100;
    settle(); expect_sel("R8 thread 3 now precedes 2", 1, 3);
    rdy = 4'b1111;
    repeat (3) @(negedge clk);
    #1; expect_sel("R8 no grant keeps order", 1, 0);
  endtask

  task automatic t_rr_status;
    set_t(0, 3'd3, 0, 1, 0); set_t(1, 3'd2, 0, 1, 0);
    set_t(2, 3'd4, 0, 1, 0); set_t(3, 3'd3, 0, 1, 0);
    settle(); expect_sel("R1 fetch-trap eligible, others blocked", 1, 2);
    set_t(2, 3'd0, 0, 1, 0);
    settle(); expect_sel("R1 idle eligible", 1, 2);
    set_t(2, 3'd3, 0, 1, 0);
    settle(); expect_sel("R9 all blocked gives none", 0, 0);
  endtask

  task automatic t_policy_hold;
    pol = 2'd2;
    all_run(50, 10, 30, 40);
    repeat (2) @(negedge clk);
    #1; expect_sel("R11 policy change ignored outside reset", 1, 0);
  endtask

  task automatic t_oldest;
    do_reset(2'd2);
    all_run(40, 30, 20, 35);
    settle(); expect_sel("R3 smallest sequence", 1, 2);
    rdy[2] = 1'b0;
    settle(); expect_sel("R2 not-ready head skipped", 1, 1);
    emp[1] = 1'b1;
    settle(); expect_sel("R2 empty buffer skipped", 1, 3);
    all_run(7, 5, 5, 9);
    settle(); expect_sel("R4 tie to lower index", 1, 1);
    set_t(1, 3'd3, 0, 1, 5);
    settle(); expect_sel("R1 trap-pending oldest skipped", 1, 2);
    rdy = '0;
    settle(); expect_sel("R9 none ready", 0, 0);
  endtask

  task automatic t_aggressive;
    do_reset(2'd0);
    @(posedge clk); #1;
    all_run(9, 8, 7, 6);
    #1; expect_sel("R5 aggressive picks oldest", 1, 3);
    rdy[3] = 1'b0;
    #1; expect_sel("R5 reselect within cycle", 1, 2);
    do_reset(2'd3);
    all_run(4, 3, 2, 1);
    settle(); expect_sel("R5 code 3 acts as oldest-ready", 1, 3);
  endtask

  task automatic t_single;
    st1 = 3'd1; emp1 = 1'b1; rdy1 = 1'b0;
    settle(); expect_one("R10 running, empty and not ready", 1);
    st1 = 3'd4;
    settle(); expect_one("R10 fetch-trap eligible", 1);
    st1 = 3'd3;
    settle(); expect_one("R10 trap pending blocked", 0);
    st1 = 3'd2; emp1 = 1'b0; rdy1 = 1'b1;
    settle(); expect_one("R10 squashing blocked", 0);
  endtask

  initial begin
    t_reset_state();
    t_rr_rotate();
    t_rr_status();
    t_policy_hold();
    t_single();
    t_oldest();
    t_aggressive();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule